// File: doc/BRIEF.md
# Adaptive Harvester Switch Sequencer

This block is the digital sequencer for the flyback switch of an electrostatic vibration energy harvester. It splits time into two phases that alternate. A short calibration window lets the analog threshold generator re-derive the two switching levels. A long harvesting phase follows, in which the block drives the switch. All timing is counted in cycles of one fast system clock. Every duration is a parameter, so the recurrence of calibration can be stretched from seconds to tens of seconds.

During harvesting, the upper-threshold comparator is looked at only once per slow harvest tick. A divider enable is raised for a few cycles up to and including that sample. When the sampled comparator reports the stored voltage above the upper level, the block emits a fixed-width "close" strobe and enters a watch phase. In the watch phase a second divider is enabled, and the lower-threshold comparator is examined on every fast cycle. A reported crossing, or a watch that runs too long, produces a fixed-width "open" strobe. If the end of the harvesting phase falls inside a flyback, calibration is deferred until the open strobe has finished.

Both comparator inputs are asynchronous and pass through two-flop synchronizers. All outputs come straight from registers.

Top module: `harvest_switch_seq`

## Requirements
- R1: While `mode_cal` is high, `sw_on`, `sw_off`, `fly_en` and `div_en` are all low.
- R2: Calibration lasts exactly CAL_LEN_CYC cycles. A new calibration window begins PERIOD_CYC cycles after the previous one began, provided no flyback straddles the end of the harvesting phase.
- R3: In harvesting, the sample cycle is the TICK_CYC-th cycle counted from entry into harvesting, and then every TICK_CYC cycles after that. `div_en` is high for the LEAD_CYC cycles that end with the sample cycle, and is low at all other times.
- R4: `up_cmp` (high means the stored voltage is above the upper level) is acted on only in a sample cycle. A high synchronized value there makes `sw_on` rise in the next cycle.
- R5: `sw_on` stays high for exactly STROBE_CYC cycles and is always followed directly by the watch phase.
- R6: In the watch phase, `lo_cmp` (high means the stored voltage is below the lower level) is checked on every cycle. A high synchronized value makes `sw_off` rise in the next cycle. `sw_off` stays high for exactly STROBE_CYC cycles, after which harvesting resumes.
- R7: `sw_on` and `sw_off` are never high in the same cycle.
- R8: `fly_en` is high exactly during the watch cycles between the end of `sw_on` and the start of `sw_off`.
- R9: If no crossing is seen, the watch ends after FLY_MAX_CYC cycles and `sw_off` is forced.
- R10: If the harvesting phase runs out during a flyback, the flyback runs to its normal end including the full `sw_off` strobe. `mode_cal` then rises in the cycle right after `sw_off` falls.
- R11: Each comparator input passes through two flops. A level applied before clock edge k is first acted on at edge k+2.
- R12: Synchronous reset puts the block in calibration: `mode_cal` high and every other output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock |
| rst | input | 1 | synchronous active-high reset |
| up_cmp | input | 1 | asynchronous upper-threshold comparator output |
| lo_cmp | input | 1 | asynchronous lower-threshold comparator output |
| mode_cal | output | 1 | high in calibration, low in harvesting |
| sw_on | output | 1 | strobe that closes the flyback switch |
| sw_off | output | 1 | strobe that opens the flyback switch |
| div_en | output | 1 | enable for the sampled stored-voltage divider |
| fly_en | output | 1 | enable for the fast flyback-phase divider |

## Verification
Two functions can fall in the same cycle: the end-of-harvest calibration request and a flyback already in progress. A lower-threshold crossing and the watch timeout can also land on the same cycle. The bench provokes the first case by holding the upper comparator high and the lower one low, which makes flybacks run back to back and end on timeout, so the harvest deadline usually lands inside a watch or a strobe. A second stretch holds both comparators high so that crossings end each watch at once. Each cycle the bench compares all outputs against a cycle model built from the requirements, and it counts the deferred calibrations and timeouts it has seen so that both cases are shown to have occurred.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [2:0] {
    ST_CAL  = 3'd0,
    ST_HARV = 3'd1,
    ST_ON   = 3'd2,
    ST_FLY  = 3'd3,
    ST_OFF  = 3'd4
  } seq_st_t;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[b] <= 1'b0;
        q[b]    <= 1'b0;
      end else begin
        meta[b] <= d[b];
        q[b]    <= meta[b];
      end
    end
  end
endmodule

// File: rtl/hsw_frame.sv
module hsw_frame #(
  parameter int HARV_LEN = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic in_cal,
  output logic due_now
);
  localparam int HW = (HARV_LEN > 2) ? $clog2(HARV_LEN) : 1;
  localparam logic [HW-1:0] HV_LAST = HW'(HARV_LEN - 1);

  logic [HW-1:0] hv_cnt;
  logic          due_q;
  logic          at_last;

  assign at_last = (hv_cnt == HV_LAST);
  assign due_now = due_q | at_last;

  always_ff @(posedge clk) begin
    if (rst || in_cal) begin
      hv_cnt <= '0;
      due_q  <= 1'b0;
    end else begin
      if (!at_last) hv_cnt <= hv_cnt + HW'(1);
      due_q <= due_now;
    end
  end
endmodule

// File: rtl/hsw_tick.sv
module hsw_tick #(
  parameter int TICK_CYC = 16,
  parameter int LEAD_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick_last,
  output logic div_en
);
  localparam int TW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
  localparam logic [TW-1:0] TK_LAST  = TW'(TICK_CYC - 1);
  localparam logic [TW-1:0] DIV_FROM = TW'(TICK_CYC - LEAD_CYC);

  logic [TW-1:0] tk;
  logic [TW-1:0] tk_nx;

  assign tick_last = (tk == TK_LAST);

  always_comb begin
    if (!run)           tk_nx = '0;
    else if (tick_last) tk_nx = '0;
    else                tk_nx = tk + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tk     <= '0;
      div_en <= 1'b0;
    end else begin
      tk     <= tk_nx;
      div_en <= run && (tk_nx >= DIV_FROM);
    end
  end
endmodule

// File: rtl/harvest_switch_seq.sv
module harvest_switch_seq
  import hsw_pkg::*;
#(
  parameter int CAL_LEN_CYC = 5_000_000,
  parameter int PERIOD_CYC  = 100_000_000,
  parameter int TICK_CYC    = 500_000,
  parameter int LEAD_CYC    = 4,
  parameter int STROBE_CYC  = 3,
  parameter int FLY_MAX_CYC = 2_500
) (
  input  logic clk,
  input  logic rst,
  input  logic up_cmp,
  input  logic lo_cmp,
  output logic mode_cal,
  output logic sw_on,
  output logic sw_off,
  output logic div_en,
  output logic fly_en
);
  localparam int HARV_LEN = PERIOD_CYC - CAL_LEN_CYC;
  localparam int CMAX0 = (CAL_LEN_CYC > STROBE_CYC) ? CAL_LEN_CYC : STROBE_CYC;
  localparam int CMAX  = (CMAX0 > FLY_MAX_CYC) ? CMAX0 : FLY_MAX_CYC;
  localparam int CW    = $clog2(CMAX + 1);
  localparam logic [CW-1:0] CAL_LAST = CW'(CAL_LEN_CYC - 1);
  localparam logic [CW-1:0] STB_LAST = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] FLY_LAST = CW'(FLY_MAX_CYC - 1);

  seq_st_t       st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic [1:0]    cmp_s;
  logic          up_s, lo_s;
  logic          due_now, tick_last, tick_run;

  hsw_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({lo_cmp, up_cmp}),
    .q   (cmp_s)
  );
  assign up_s = cmp_s[0];
  assign lo_s = cmp_s[1];

  hsw_frame #(.HARV_LEN(HARV_LEN)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .in_cal  (st == ST_CAL),
    .due_now (due_now)
  );

  assign tick_run = (st == ST_HARV) && (st_nx == ST_HARV);

  hsw_tick #(.TICK_CYC(TICK_CYC), .LEAD_CYC(LEAD_CYC)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .run       (tick_run),
    .tick_last (tick_last),
    .div_en    (div_en)
  );

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt + CW'(1);
    unique case (st)
      ST_CAL: begin
        if (cnt == CAL_LAST) begin
          st_nx  = ST_HARV;
          cnt_nx = '0;
        end
      end
      ST_HARV: begin
        cnt_nx = '0;
        if (due_now)                st_nx = ST_CAL;
        else if (tick_last && up_s) st_nx = ST_ON;
      end
      ST_ON: begin
        if (cnt == STB_LAST) begin
          st_nx  = ST_FLY;
          cnt_nx = '0;
        end
      end
      ST_FLY: begin
        if (lo_s || cnt == FLY_LAST) begin
          st_nx  = ST_OFF;
          cnt_nx = '0;
        end
      end
      ST_OFF: begin
        if (cnt == STB_LAST) begin
          st_nx  = due_now ? ST_CAL : ST_HARV;
          cnt_nx = '0;
        end
      end
      default: begin
        st_nx  = ST_CAL;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_CAL;
      cnt      <= '0;
      mode_cal <= 1'b1;
      sw_on    <= 1'b0;
      sw_off   <= 1'b0;
      fly_en   <= 1'b0;
    end else begin
      st       <= st_nx;
      cnt      <= cnt_nx;
      mode_cal <= (st_nx == ST_CAL);
      sw_on    <= (st_nx == ST_ON);
      sw_off   <= (st_nx == ST_OFF);
      fly_en   <= (st_nx == ST_FLY);
    end
  end

  AST_CAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    mode_cal |-> !(sw_on || sw_off || fly_en || div_en)); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sw_on && sw_off)); // R7
  AST_ON_THEN_WATCH: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_on) |-> fly_en); // R5
  AST_OFF_AFTER_WATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_off) |-> $past(fly_en)); // R8
  AST_WATCH_NO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    fly_en |-> !div_en); // R3
  AST_OFF_EXIT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_off) |-> !(fly_en || sw_on)); // R6
endmodule

// File: tb/harvest_switch_seq_tb_top.sv
module harvest_switch_seq_tb_top;
  localparam int CALN = 20;
  localparam int PER  = 400;
  localparam int TCK  = 16;
  localparam int LEAD = 3;
  localparam int STB  = 3;
  localparam int FMAX = 30;
  localparam int HL   = PER - CALN;
  localparam int M_CAL = 0, M_HARV = 1, M_ON = 2, M_FLY = 3, M_OFF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b0;
  logic lo = 1'b0;
  logic mode_cal, sw_on, sw_off, div_en, fly_en;

  always #10 clk = ~clk;

  harvest_switch_seq #(
    .CAL_LEN_CYC(CALN), .PERIOD_CYC(PER), .TICK_CYC(TCK),
    .LEAD_CYC(LEAD), .STROBE_CYC(STB), .FLY_MAX_CYC(FMAX)
  ) dut_i (
    .clk(clk), .rst(rst), .up_cmp(up), .lo_cmp(lo),
    .mode_cal(mode_cal), .sw_on(sw_on), .sw_off(sw_off),
    .div_en(div_en), .fly_en(fly_en)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  int ms, mcnt, mhv, mtk;
  bit mdue, u1, u2, l1, l2;
  int n_to = 0, n_def = 0, n_lo = 0, n_on = 0;

  // Cycle model written from the requirements.
  always @(posedge clk) begin : ref_model
    int nx, nc;
    bit dn, tl;
    if (rst) begin
      ms = M_CAL; mcnt = 0; mhv = 0; mtk = 0; mdue = 0;
      u1 = 0; u2 = 0; l1 = 0; l2 = 0;
    end else begin
      dn = mdue || (mhv == HL - 1);
      tl = (mtk == TCK - 1);
      nx = ms;
      nc = mcnt + 1;
      case (ms)
        M_CAL:  if (mcnt == CALN - 1) begin nx = M_HARV; nc = 0; end
        M_HARV: begin
          nc = 0;
          if (dn) nx = M_CAL;
          else if (tl && u2) begin nx = M_ON; n_on++; end
        end
        M_ON:   if (mcnt == STB - 1) begin nx = M_FLY; nc = 0; end
        M_FLY:  if (l2 || mcnt == FMAX - 1) begin
          nx = M_OFF; nc = 0;
          if (l2) n_lo++; else n_to++;
        end
        default: if (mcnt == STB - 1) begin
          nc = 0;
          if (dn) begin nx = M_CAL; n_def++; end else nx = M_HARV;
        end
      endcase
      if (ms == M_CAL) begin mhv = 0; mdue = 0; end
      else begin
        if (mhv != HL - 1) mhv++;
        mdue = dn;
      end
      mtk = (ms == M_HARV && nx == M_HARV) ? (tl ? 0 : mtk + 1) : 0;
      ms = nx;
      mcnt = nc;
      u2 = u1; u1 = up;
      l2 = l1; l1 = lo;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk(mode_cal == (ms == M_CAL), "R2 mode_cal", int'(mode_cal), int'(ms == M_CAL));
    chk(sw_on == (ms == M_ON), "R4 R5 R11 sw_on", int'(sw_on), int'(ms == M_ON));
    chk(sw_off == (ms == M_OFF), "R6 R9 R10 sw_off", int'(sw_off), int'(ms == M_OFF));
    chk(fly_en == (ms == M_FLY), "R8 fly_en", int'(fly_en), int'(ms == M_FLY));
    chk(div_en == (ms == M_HARV && mtk >= TCK - LEAD), "R3 div_en", int'(div_en),
        int'(ms == M_HARV && mtk >= TCK - LEAD));
    if (mode_cal)
      chk(!(sw_on || sw_off || fly_en || div_en), "R1 quiet in calibration",
          int'({sw_on, sw_off, fly_en, div_en}), 0);
    if (sw_on) chk(!sw_off, "R7 strobe overlap", int'(sw_off), 0);
  endtask

  task automatic chk_reset();
    chk(mode_cal == 1'b1, "R12 mode_cal after reset", int'(mode_cal), 1);
    chk({sw_on, sw_off, fly_en, div_en} == 4'b0, "R12 outputs after reset",
        int'({sw_on, sw_off, fly_en, div_en}), 0);
  endtask

  // phase: 0 random, 1 up high/lo low, 2 both high
  task automatic run_cycles(input int n, input int phase);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_all();
      case (phase)
        1: begin up = 1'b1; lo = 1'b0; end
        2: begin up = 1'b1; lo = 1'b1; end
        default: begin
          up = (($urandom % 100) < 30);
          lo = (($urandom % 100) < 8);
        end
      endcase
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk_reset();
    rst = 1'b0;
    run_cycles(1000, 0);
    run_cycles(2500, 1);
    run_cycles(1000, 2);
    // reset in the middle of operation
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_reset();
    rst = 1'b0;
    run_cycles(6000, 0);
    run_cycles(1500, 1);
    chk(n_on > 0, "R4 close strobes seen", n_on, 1);
    chk(n_lo > 0, "R6 crossings seen", n_lo, 1);
    chk(n_to > 0, "R9 timeouts seen", n_to, 1);
    chk(n_def > 0, "R10 deferred calibrations seen", n_def, 1);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule